// File: doc/BRIEF.md
# Debug Port Posted Access Controller

This block sits behind a serial debug link engine and decides, for each decoded host transaction, whether to answer OK or WAIT and what data to return. Reads of the local debug-port registers are not posted: the controller returns their data in the response. Reads of the access port are posted. An accepted access-port read returns the result of the previous access-port read and starts the new one on the access-port side. A read-buffer register gives the host the last posted result without starting another access.

Writes to either port go into a small in-order write buffer, so the host can keep issuing writes while earlier work is still outstanding. The controller answers WAIT only when the buffer is full, or when a read would otherwise return stale or unordered data. A status word reports whether the most recent access-port read succeeded, and holds a sticky flag for any access-port error. The access port is modelled as a simple request/ready handshake with a data return and an error line.

Top module: `dpac_top`

## Requirements
- R1: Each host request in cycle t produces exactly one response in cycle t+1. A debug-port read (select in req_addr[1:0]: 0 identity, 1 status, 2 scratch, 3 read buffer) is answered OK with that register's value when the write buffer is empty and no access-port read is in flight. Otherwise it is answered WAIT with zero data and has no effect. The identity register reads as the IDCODE parameter.
- R2: An accepted access-port read is answered OK with the result of the previous access-port read. It then raises ap_req with ap_wr low and ap_addr equal to the requested address in the next cycle.
- R3: A read-buffer read returns the most recent access-port read result and issues no access-port request.
- R4: Status bit 0 (read-OK) takes the value 1 when an access-port read completes without error and 0 when it completes with ap_err. Its value after reset is 0.
- R5: A write to either port is answered OK and stored when the buffer holds fewer than 2 entries, including while an access-port read is in flight.
- R6: A write that arrives while the buffer holds 2 entries is answered WAIT and dropped.
- R7: Stored writes leave in acceptance order. An access-port write holds ap_req, ap_wr, ap_addr and ap_wdata steady until ap_rdy. A pending access-port read is served before any write accepted after it. A debug-port write takes effect one cycle after it reaches the head of the buffer.
- R8: An access-port read that arrives while the write buffer is not empty, or while an earlier access-port read is still in flight, is answered WAIT and starts nothing.
- R9: Status bit 1 (sticky error) is set by any access-port completion with ap_err, read or write. A debug-port write to status with data bit 1 set clears it.
- R10: Debug-port writes to the identity and read-buffer selects are ignored. A write to scratch is read back unchanged.
- R11: While reset is held and after it is released, rsp_valid and ap_req are low, and status and the read buffer read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host transaction present this cycle |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register select / access-port address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_wait | output | 1 | 1 = WAIT, 0 = OK |
| rsp_rdata | output | DATA_W | Read data for an OK read, else zero |
| ap_req | output | 1 | Access-port request |
| ap_wr | output | 1 | Access-port request is a write |
| ap_addr | output | ADDR_W | Access-port address |
| ap_wdata | output | DATA_W | Access-port write data |
| ap_rdy | input | 1 | Access port completes the request this cycle |
| ap_rdata | input | DATA_W | Access-port read data, valid with ap_rdy |
| ap_err | input | 1 | Access-port error, valid with ap_rdy |

## Verification
The response to a request in cycle t is due one cycle later. An accepted access-port read shows ap_req in the next cycle. A completion with ap_rdy updates the read buffer and status flags at that edge, and a debug-port write at the buffer head becomes visible one cycle after it reaches the head. The bench drives inputs and compares outputs on the falling edge. Its behavioural model advances on the rising edge using the same registered view, so every comparison of responses and access-port outputs falls in the exact cycle the result is due. Directed reads retry on WAIT and then check values that follow from the requirements alone.

// File: rtl/dpac_pkg.sv
package dpac_pkg;
  typedef enum logic [1:0] {
    SEL_IDENT   = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_SCRATCH = 2'd2,
    SEL_RDBUF   = 2'd3
  } dp_sel_e;

  localparam int STAT_OK_BIT  = 0;
  localparam int STAT_ERR_BIT = 1;
endpackage

// File: rtl/dpac_wbuf.sv
module dpac_wbuf #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic load;
    assign load = push && (wr_ptr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[g] <= '0;
      else if (load) slot_q[g] <= din;
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) !(push && full));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty));
endmodule

// File: rtl/dpac_apseq.sv
module dpac_apseq #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              empty,
  input  logic              head_ap,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic              ap_rdy,
  input  logic              ap_err,
  output logic              rd_pend,
  output logic              pop,
  output logic              dp_wr_en,
  output logic [1:0]        dp_wr_sel,
  output logic [DATA_W-1:0] dp_wr_data,
  output logic              rd_done,
  output logic              err_evt,
  output logic              ap_req,
  output logic              ap_wr,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_wdata
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] raddr_q;
  logic              done;

  always_comb begin
    ap_req     = pend_q || (!empty && head_ap);
    ap_wr      = !pend_q;
    ap_addr    = pend_q ? raddr_q : head_addr;
    ap_wdata   = head_data;
    done       = ap_req && ap_rdy;
    rd_done    = done && pend_q;
    err_evt    = done && ap_err;
    dp_wr_en   = !pend_q && !empty && !head_ap;
    dp_wr_sel  = head_addr[1:0];
    dp_wr_data = head_data;
    pop        = !pend_q && !empty && (head_ap ? ap_rdy : 1'b1);
    pend_d     = pend_q;
    if (rd_start)     pend_d = 1'b1;
    else if (rd_done) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raddr_q <= '0;
    else if (rd_start) raddr_q <= rd_addr;
  end

  assign rd_pend = pend_q;

  // R7
  ap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_req && !ap_rdy) |=> (ap_req && $stable(ap_wr) && $stable(ap_addr) && (!ap_wr || $stable(ap_wdata))));
  // R2
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (ap_req && !ap_wr));
endmodule

// File: rtl/dpac_regs.sv
module dpac_regs
  import dpac_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] IDCODE = 32'h5EED_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_done,
  input  logic              ap_err,
  input  logic              err_evt,
  input  logic [DATA_W-1:0] ap_rdata,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdbuf
);
  logic [DATA_W-1:0] scratch_q, scratch_d, rdbuf_q, rdbuf_d;
  logic              rok_q, rok_d, stk_q, stk_d;
  logic              clr_err;

  always_comb begin
    clr_err   = wr_en && (wr_sel == SEL_STATUS) && wr_data[STAT_ERR_BIT];
    scratch_d = (wr_en && wr_sel == SEL_SCRATCH) ? wr_data : scratch_q;
    rdbuf_d   = rd_done ? ap_rdata : rdbuf_q;
    rok_d     = rd_done ? !ap_err : rok_q;
    stk_d     = stk_q;
    if (err_evt)      stk_d = 1'b1;
    else if (clr_err) stk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      rdbuf_q   <= '0;
      rok_q     <= 1'b0;
      stk_q     <= 1'b0;
    end else begin
      scratch_q <= scratch_d;
      rdbuf_q   <= rdbuf_d;
      rok_q     <= rok_d;
      stk_q     <= stk_d;
    end
  end

  always_comb begin
    unique case (dp_sel_e'(rd_sel))
      SEL_IDENT:   rd_word = DATA_W'(IDCODE);
      SEL_STATUS: begin
        rd_word = '0;
        rd_word[STAT_OK_BIT]  = rok_q;
        rd_word[STAT_ERR_BIT] = stk_q;
      end
      SEL_SCRATCH: rd_word = scratch_q;
      default:     rd_word = rdbuf_q;
    endcase
  end

  assign rdbuf = rdbuf_q;

  // R4
  rok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && ap_err) |=> !rok_q);
  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stk_q);
endmodule

// File: rtl/dpac_top.sv
module dpac_top #(
  parameter int          ADDR_W   = 2,
  parameter int          DATA_W   = 32,
  parameter int          WB_DEPTH = 2,
  parameter logic [31:0] IDCODE   = 32'h5EED_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_wait,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ap_req,
  output logic              ap_wr,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [DATA_W-1:0] ap_wdata,
  input  logic              ap_rdy,
  input  logic [DATA_W-1:0] ap_rdata,
  input  logic              ap_err
);
  localparam int EW = 1 + ADDR_W + DATA_W;

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic              push, pop, empty, full, busy;
  logic [EW-1:0]     head;
  logic              rd_start, rd_pend, dp_wr_en, rd_done, err_evt;
  logic [1:0]        dp_wr_sel;
  logic [DATA_W-1:0] dp_wr_data, dp_word, rdbuf;
  logic              rsp_valid_q, rsp_wait_q, rsp_valid_d, rsp_wait_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  always_comb begin
    busy        = rd_pend || !empty;
    push        = req_valid && !req_rnw && !full;
    rd_start    = req_valid && req_rnw && req_ap && !busy;
    rsp_valid_d = req_valid;
    rsp_wait_d  = req_valid && (req_rnw ? busy : full);
    rsp_rdata_d = '0;
    if (req_valid && req_rnw && !busy) rsp_rdata_d = req_ap ? rdbuf : dp_word;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid_q <= 1'b0;
      rsp_wait_q  <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_wait_q  <= rsp_wait_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  dpac_wbuf #(.W(EW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_q), .push(push), .pop(pop),
    .din({req_ap, req_addr, req_wdata}), .head(head), .empty(empty), .full(full)
  );

  dpac_apseq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_apseq (
    .clk(clk), .rst_n(rst_q), .rd_start(rd_start), .rd_addr(req_addr),
    .empty(empty), .head_ap(head[EW-1]), .head_addr(head[DATA_W +: ADDR_W]),
    .head_data(head[DATA_W-1:0]), .ap_rdy(ap_rdy), .ap_err(ap_err),
    .rd_pend(rd_pend), .pop(pop), .dp_wr_en(dp_wr_en), .dp_wr_sel(dp_wr_sel),
    .dp_wr_data(dp_wr_data), .rd_done(rd_done), .err_evt(err_evt),
    .ap_req(ap_req), .ap_wr(ap_wr), .ap_addr(ap_addr), .ap_wdata(ap_wdata)
  );

  dpac_regs #(.DATA_W(DATA_W), .IDCODE(IDCODE)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(dp_wr_en), .wr_sel(dp_wr_sel),
    .wr_data(dp_wr_data), .rd_done(rd_done), .ap_err(ap_err), .err_evt(err_evt),
    .ap_rdata(ap_rdata), .rd_sel(req_addr[1:0]), .rd_word(dp_word), .rdbuf(rdbuf)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_wait  = rsp_wait_q;
  assign rsp_rdata = rsp_rdata_q;

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> rsp_valid);
  // R6
  full_wait_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !req_rnw && full && !pop) |=> (rsp_wait && full));
endmodule

// File: tb/dpac_top_bench.sv
module dpac_top_bench;
  localparam logic [31:0] ID = 32'h5EED_0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ap, req_rnw;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_wait;
  logic [31:0] rsp_rdata;
  logic        ap_req, ap_wr, ap_rdy, ap_err;
  logic [1:0]  ap_addr;
  logic [31:0] ap_wdata, ap_rdata;

  always #10 clk = ~clk;

  dpac_top #(.ADDR_W(2), .DATA_W(32), .WB_DEPTH(2), .IDCODE(ID)) u_dpac_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_wait(rsp_wait), .rsp_rdata(rsp_rdata),
    .ap_req(ap_req), .ap_wr(ap_wr), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_rdy(ap_rdy), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd_pat(input int a);
    return 32'hC0DE_0000 + 32'(a) * 32'h111;
  endfunction

  // behavioural model
  typedef struct { bit ap; int addr; logic [31:0] data; } ent_t;
  ent_t        q[$];
  bit          m_pend, m_rok, m_stk;
  int          m_raddr, wcnt, lat = 0, err_addr = 0;
  bit          err_en = 0;
  logic [31:0] m_rdbuf, m_scr, dpw;
  bit          e_valid, e_wait;
  logic [31:0] e_data;
  string       m_tag = "R11";
  int          sz0;
  bit          busy0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_pend = 0; m_raddr = 0; m_rok = 0; m_stk = 0; wcnt = 0;
      m_rdbuf = 0; m_scr = 0; e_valid = 0; e_wait = 0; e_data = 0; m_tag = "R11";
    end else begin
      sz0 = q.size();
      busy0 = m_pend || (sz0 != 0);
      case (req_addr)
        2'd0: dpw = ID;
        2'd1: dpw = {30'b0, m_stk, m_rok};
        2'd2: dpw = m_scr;
        default: dpw = m_rdbuf;
      endcase
      if (m_pend) begin
        if (ap_rdy) begin
          m_rdbuf = ap_rdata; m_rok = !ap_err; if (ap_err) m_stk = 1; m_pend = 0; wcnt = 0;
        end else wcnt++;
      end else if (sz0 != 0) begin
        if (q[0].ap) begin
          if (ap_rdy) begin
            if (ap_err) m_stk = 1;
            void'(q.pop_front()); wcnt = 0;
          end else wcnt++;
        end else begin
          if (q[0].addr == 2) m_scr = q[0].data;
          if (q[0].addr == 1 && q[0].data[1]) m_stk = 0;
          void'(q.pop_front());
        end
      end
      e_valid = req_valid; e_wait = 0; e_data = 0;
      if (req_valid) begin
        if (!req_rnw) begin
          e_wait = (sz0 == 2);
          m_tag = e_wait ? "R6" : "R5";
          if (!e_wait) q.push_back('{ap: req_ap, addr: int'(req_addr), data: req_wdata});
        end else begin
          e_wait = busy0;
          if (req_ap) m_tag = busy0 ? "R8" : "R2";
          else m_tag = (req_addr == 2'd3) ? "R3" : (req_addr == 2'd1) ? "R4" : "R1";
          if (!busy0) begin
            e_data = req_ap ? m_rdbuf : dpw;
            if (req_ap) begin m_pend = 1; m_raddr = int'(req_addr); end
          end
        end
      end
    end
  end

  // per-cycle comparison and access-port responder
  always @(negedge clk) begin
    bit er; int ea; bit ew;
    er = m_pend || (q.size() > 0 && q[0].ap);
    ew = !m_pend;
    ea = m_pend ? m_raddr : (q.size() > 0 ? q[0].addr : 0);
    if (!finished) begin
      chk(rsp_valid == e_valid, {m_tag, " rsp_valid"}, 32'(rsp_valid), 32'(e_valid));
      if (e_valid) begin
        chk(rsp_wait == e_wait, {m_tag, " rsp_wait"}, 32'(rsp_wait), 32'(e_wait));
        chk(rsp_rdata == e_data, {m_tag, " rsp_rdata"}, rsp_rdata, e_data);
      end
      chk(ap_req == er, "R7 ap_req", 32'(ap_req), 32'(er));
      if (er) begin
        chk(ap_wr == ew, "R7 ap_wr", 32'(ap_wr), 32'(ew));
        chk(int'(ap_addr) == ea, "R7 ap_addr", 32'(ap_addr), 32'(ea));
        if (ew) chk(ap_wdata == q[0].data, "R7 ap_wdata", ap_wdata, q[0].data);
      end
    end
    ap_rdy   = er && (wcnt >= lat);
    ap_rdata = rd_pat(ea);
    ap_err   = er && err_en && (ea == err_addr);
  end

  task automatic issue(input bit ap, input bit rnw, input int a, input logic [31:0] d);
    req_valid = 1; req_ap = ap; req_rnw = rnw; req_addr = 2'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_ap = 0; req_rnw = 0; req_addr = 0; req_wdata = 0;
  endtask

  task automatic wr(input bit ap, input int a, input logic [31:0] d, output bit wt);
    issue(ap, 0, a, d);
    wt = rsp_wait;
  endtask

  task automatic rd_ok(input bit ap, input int a, output logic [31:0] d);
    bit done = 0;
    while (!done) begin
      issue(ap, 1, a, 0);
      if (!rsp_wait) begin d = rsp_rdata; done = 1; end
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    bit wt;
    req_valid = 0; req_ap = 0; req_rnw = 0; req_addr = 0; req_wdata = 0;
    ap_rdy = 0; ap_rdata = 0; ap_err = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && ap_req == 0, "R11 outputs in reset", {rsp_valid, ap_req}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 0 && ap_req == 0, "R11 outputs after reset", {rsp_valid, ap_req}, 0);
    rd_ok(0, 1, d); chk(d == 0, "R11 status", d, 0);
    rd_ok(0, 3, d); chk(d == 0, "R11 rdbuf", d, 0);
    rd_ok(0, 0, d); chk(d == ID, "R1 identity", d, ID);

    // debug-port writes
    wr(0, 2, 32'h1234_5678, wt); chk(wt == 0, "R5 dp write ok", wt, 0);
    rd_ok(0, 2, d); chk(d == 32'h1234_5678, "R10 scratch", d, 32'h1234_5678);
    wr(0, 0, 32'hFFFF_FFFF, wt);
    wr(0, 3, 32'hFFFF_FFFF, wt);
    rd_ok(0, 0, d); chk(d == ID, "R10 identity unchanged", d, ID);
    rd_ok(0, 3, d); chk(d == 0, "R10 rdbuf unchanged", d, 0);

    // buffer full and ordering
    lat = 3;
    wr(1, 0, 32'h11, wt); chk(wt == 0, "R5 first write", wt, 0);
    wr(1, 1, 32'h22, wt); chk(wt == 0, "R5 second write", wt, 0);
    wr(1, 2, 32'h33, wt); chk(wt == 1, "R6 third write waits", wt, 1);
    issue(1, 1, 1, 0);    chk(rsp_wait == 1, "R8 read behind writes", rsp_wait, 1);
    rd_ok(1, 1, d);       chk(d == 0, "R2 first posted read", d, 0);
    wr(1, 3, 32'h44, wt); chk(wt == 0, "R5 write during read", wt, 0);
    issue(1, 1, 2, 0);    chk(rsp_wait == 1, "R8 read in flight", rsp_wait, 1);
    rd_ok(1, 2, d);       chk(d == rd_pat(1), "R2 previous result", d, rd_pat(1));
    rd_ok(0, 3, d);       chk(d == rd_pat(2), "R3 rdbuf latest", d, rd_pat(2));
    rd_ok(0, 3, d);       chk(d == rd_pat(2), "R3 rdbuf repeat", d, rd_pat(2));
    @(negedge clk);       chk(ap_req == 0, "R3 no access issued", 32'(ap_req), 0);

    // errors
    err_en = 1; err_addr = 3;
    rd_ok(1, 3, d);  chk(d == rd_pat(2), "R2 read before error", d, rd_pat(2));
    rd_ok(0, 3, d);  chk(d == rd_pat(3), "R3 errored data", d, rd_pat(3));
    rd_ok(0, 1, d);  chk(d == 32'h2, "R4 read-OK cleared, R9 sticky", d, 32'h2);
    rd_ok(1, 0, d);  chk(d == rd_pat(3), "R2 after error", d, rd_pat(3));
    rd_ok(0, 3, d);  chk(d == rd_pat(0), "R3 good read", d, rd_pat(0));
    rd_ok(0, 1, d);  chk(d == 32'h3, "R4 read-OK set, R9 sticky kept", d, 32'h3);
    wr(0, 1, 32'h2, wt);
    rd_ok(0, 1, d);  chk(d == 32'h1, "R9 sticky cleared", d, 32'h1);
    wr(1, 3, 32'h55, wt);
    rd_ok(0, 1, d);  chk(d == 32'h3, "R9 write error sticky", d, 32'h3);
    err_en = 0;

    // zero-latency burst, model compares every cycle
    lat = 0;
    wr(1, 1, 32'hA1, wt);
    wr(1, 2, 32'hA2, wt);
    wr(0, 2, 32'hBEEF, wt);
    rd_ok(1, 2, d); chk(d == rd_pat(0), "R2 zero latency", d, rd_pat(0));
    wr(1, 0, 32'hA3, wt);
    rd_ok(0, 2, d); chk(d == 32'hBEEF, "R7 dp write in order", d, 32'hBEEF);
    rd_ok(0, 3, d); chk(d == rd_pat(2), "R3 final rdbuf", d, rd_pat(2));
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule